// File: doc/BRIEF.md
# Warp-Group Shortest-Job Transaction Scheduler

This block sits between the read-request input of a GPU memory controller and its per-bank command queues. Each arriving read carries the identity of the SIMD core and the warp that issued it, the target bank and row, and a flag that marks the last request this warp sends to this controller. Requests from the same core and warp are collected into one group entry. A group becomes eligible once its closing flag has arrived, or once it holds as many requests as an entry can store.

For every eligible group the block estimates a completion score. Each request is scored as its access cost plus the backlog already queued on its bank. The access cost is 1 for a row hit and 3 for a row miss. The group's score is the largest of its request scores. The group with the lowest score is sent whole, one request per cycle, before any other group is chosen. A per-bank table remembers the row last sent to each bank and the cost still outstanding there. That backlog grows when a request is sent and shrinks when the command queue reports an executed request on the completion input.

Top module: `wgs_sched`

## Requirements
- R1: Requests with the same {in_sm, in_warp} pair gather in one open group; a group is sent in arrival order and every request sent carries the group's core and warp identity on out_sm and out_warp.
- R2: A group is not sent before it is closed; it closes when a request with in_last=1 joins it or when it reaches GROUP_DEPTH requests (default 8), and the closing request is the one sent with out_last=1.
- R3: out_cost is 1 when the request's row equals the row most recently sent to the same bank, and 3 otherwise, including for a bank that has not been used since reset.
- R4: A request's score is its cost plus the bank's outstanding backlog. A group's score is the maximum over its requests. Among closed groups, the lowest score is sent first.
- R5: Between closed groups with equal scores, the group with more row-hit requests is sent first.
- R6: Between groups equal in score and hit count, the lower entry index is sent first; a new group takes the lowest free entry.
- R7: A selected group is sent in consecutive cycles, one request per cycle. There is exactly one idle cycle after its final request before the next group starts.
- R8: Sending a request adds its cost to its bank's backlog. A completion pulse (done_valid with done_bank, done_cost) subtracts done_cost from that bank's backlog. The backlog does not go below zero.
- R9: in_ready is low exactly when the request's {in_sm, in_warp} matches no open group and every entry is in use; it is high for a warp that already has an open group.
- R10: After reset, in_ready is 1, out_valid is 0, every entry is free, and every bank has zero backlog and no remembered row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Read request present |
| in_ready | output | 1 | Request accepted on this edge when in_valid is high |
| in_sm | input | SM_W | Issuing core identifier |
| in_warp | input | WARP_W | Issuing warp identifier |
| in_bank | input | log2(NUM_BANKS) | Target bank |
| in_row | input | ROW_W | Target row |
| in_last | input | 1 | Final request of this warp to this controller |
| out_valid | output | 1 | Request sent to a command queue this cycle |
| out_sm | output | SM_W | Core identifier of the sent request |
| out_warp | output | WARP_W | Warp identifier of the sent request |
| out_bank | output | log2(NUM_BANKS) | Bank of the sent request |
| out_row | output | ROW_W | Row of the sent request |
| out_cost | output | 2 | Cost of the sent request: 1 hit, 3 miss |
| out_last | output | 1 | Sent request is the final one of its group |
| done_valid | input | 1 | Command queue finished a request |
| done_bank | input | log2(NUM_BANKS) | Bank of the finished request |
| done_cost | input | 2 | Cost to remove from that bank's backlog |

## Verification
Backlog and remembered-row state is visible only through the order of groups and the cost values sent. A wrong bank entry therefore appears as a wrong out_cost on the next request to that bank. It also appears as an inverted group order the next time two closed groups compete, and that happens within a group's length of the competing groups closing. The scenarios make groups compete while a long group is being sent, so that a bad score, hit count or index tie-break reorders a sequence whose order is fixed. A corrupted group entry or pointer shows up in the same cycle as a wrong identity, a broken run of consecutive requests, or a misplaced out_last.

// File: rtl/wgs_pkg.sv
package wgs_pkg;

    typedef enum logic {
        ST_PICK = 1'b0,
        ST_SEND = 1'b1
    } disp_state_e;

    localparam int unsigned COST_W = 2;

    function automatic logic [COST_W-1:0] req_cost(input logic is_hit);
        return is_hit ? 2'd1 : 2'd3;
    endfunction

endpackage

// File: rtl/wgs_group_table.sv
module wgs_group_table #(
    parameter int NG     = 8,
    parameter int ND     = 8,
    parameter int SM_W   = 4,
    parameter int WARP_W = 6,
    parameter int BANK_W = 4,
    parameter int ROW_W  = 12,
    localparam int IDX_W  = (NG > 1) ? $clog2(NG) : 1,
    localparam int CNT_W  = $clog2(ND + 1),
    localparam int SLOT_W = (ND > 1) ? $clog2(ND) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SM_W-1:0]   in_sm,
    input  logic [WARP_W-1:0] in_warp,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [ROW_W-1:0]  in_row,
    input  logic              in_last,
    input  logic              free_valid,
    input  logic [IDX_W-1:0]  free_idx,
    output logic              ent_vld    [NG],
    output logic              ent_closed [NG],
    output logic [CNT_W-1:0]  ent_cnt    [NG],
    output logic [SM_W-1:0]   ent_sm     [NG],
    output logic [WARP_W-1:0] ent_warp   [NG],
    output logic [BANK_W-1:0] ent_bank   [NG][ND],
    output logic [ROW_W-1:0]  ent_row    [NG][ND]
);

    logic             hit_open;
    logic [IDX_W-1:0] hit_idx;
    logic             have_free;
    logic [IDX_W-1:0] free_slot;
    logic [IDX_W-1:0] tgt;
    logic [SLOT_W-1:0] wr_slot;
    logic [CNT_W-1:0] new_cnt;
    logic             take;

    always_comb begin
        hit_open = 1'b0;
        hit_idx  = '0;
        for (int g = 0; g < NG; g++) begin
            if (ent_vld[g] && !ent_closed[g] && ent_sm[g] == in_sm && ent_warp[g] == in_warp) begin
                hit_open = 1'b1;
                hit_idx  = IDX_W'(g);
            end
        end
        have_free = 1'b0;
        free_slot = '0;
        for (int g = NG - 1; g >= 0; g--) begin
            if (!ent_vld[g]) begin
                have_free = 1'b1;
                free_slot = IDX_W'(g);
            end
        end
        in_ready = hit_open || have_free;
        take     = in_valid && in_ready;
        tgt      = hit_open ? hit_idx : free_slot;
        wr_slot  = hit_open ? SLOT_W'(ent_cnt[hit_idx]) : '0;
        new_cnt  = hit_open ? ent_cnt[hit_idx] + CNT_W'(1) : CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < NG; g++) begin
                ent_vld[g]    <= 1'b0;
                ent_closed[g] <= 1'b0;
                ent_cnt[g]    <= '0;
                ent_sm[g]     <= '0;
                ent_warp[g]   <= '0;
            end
        end else begin
            if (free_valid) begin
                ent_vld[free_idx]    <= 1'b0;
                ent_closed[free_idx] <= 1'b0;
                ent_cnt[free_idx]    <= '0;
            end
            if (take) begin
                ent_vld[tgt]    <= 1'b1;
                ent_sm[tgt]     <= in_sm;
                ent_warp[tgt]   <= in_warp;
                ent_cnt[tgt]    <= new_cnt;
                ent_closed[tgt] <= in_last || (new_cnt == CNT_W'(ND));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            ent_bank[tgt][wr_slot] <= in_bank;
            ent_row[tgt][wr_slot]  <= in_row;
        end
    end

endmodule

// File: rtl/wgs_bank_table.sv
module wgs_bank_table #(
    parameter int NB      = 16,
    parameter int ROW_W   = 12,
    parameter int SCORE_W = 9,
    localparam int BANK_W   = (NB > 1) ? $clog2(NB) : 1,
    localparam int PEND_MAX = (1 << SCORE_W) - 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_valid,
    input  logic [BANK_W-1:0]  upd_bank,
    input  logic [ROW_W-1:0]   upd_row,
    input  logic [1:0]         upd_cost,
    input  logic               done_valid,
    input  logic [BANK_W-1:0]  done_bank,
    input  logic [1:0]         done_cost,
    output logic [ROW_W-1:0]   last_row [NB],
    output logic               row_seen [NB],
    output logic [SCORE_W-1:0] pend     [NB]
);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [SCORE_W-1:0] pend_q;
        logic [ROW_W-1:0]   row_q;
        logic               seen_q;
        logic               is_upd;
        logic [SCORE_W:0]   sum_b;
        logic [SCORE_W:0]   dec_b;
        logic [SCORE_W:0]   sub_b;
        logic [SCORE_W-1:0] nxt_b;

        always_comb begin
            is_upd = upd_valid && (upd_bank == BANK_W'(b));
            sum_b  = {1'b0, pend_q} + (is_upd ? (SCORE_W+1)'(upd_cost) : '0);
            dec_b  = (done_valid && done_bank == BANK_W'(b)) ? (SCORE_W+1)'(done_cost) : '0;
            sub_b  = (sum_b > dec_b) ? (sum_b - dec_b) : '0;
            nxt_b  = (sub_b > (SCORE_W+1)'(PEND_MAX)) ? SCORE_W'(PEND_MAX) : sub_b[SCORE_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= '0;
                row_q  <= '0;
                seen_q <= 1'b0;
            end else begin
                pend_q <= nxt_b;
                if (is_upd) begin
                    row_q  <= upd_row;
                    seen_q <= 1'b1;
                end
            end
        end

        assign pend[b]     = pend_q;
        assign last_row[b] = row_q;
        assign row_seen[b] = seen_q;
    end

endmodule

// File: rtl/wgs_picker.sv
module wgs_picker
    import wgs_pkg::*;
#(
    parameter int NG      = 8,
    parameter int ND      = 8,
    parameter int NB      = 16,
    parameter int ROW_W   = 12,
    parameter int SCORE_W = 9,
    localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1,
    localparam int IDX_W  = (NG > 1) ? $clog2(NG) : 1,
    localparam int CNT_W  = $clog2(ND + 1)
) (
    input  logic               ent_vld    [NG],
    input  logic               ent_closed [NG],
    input  logic [CNT_W-1:0]   ent_cnt    [NG],
    input  logic [BANK_W-1:0]  ent_bank   [NG][ND],
    input  logic [ROW_W-1:0]   ent_row    [NG][ND],
    input  logic [ROW_W-1:0]   last_row   [NB],
    input  logic               row_seen   [NB],
    input  logic [SCORE_W-1:0] pend       [NB],
    output logic               pick_valid,
    output logic [IDX_W-1:0]   pick_idx
);

    logic [SCORE_W-1:0] gscore [NG];
    logic [CNT_W-1:0]   ghits  [NG];

    for (genvar g = 0; g < NG; g++) begin : g_score
        always_comb begin
            logic [BANK_W-1:0]  bk;
            logic               hit;
            logic [SCORE_W-1:0] sc;
            gscore[g] = '0;
            ghits[g]  = '0;
            for (int s = 0; s < ND; s++) begin
                bk  = ent_bank[g][s];
                hit = row_seen[bk] && (last_row[bk] == ent_row[g][s]);
                sc  = pend[bk] + SCORE_W'(req_cost(hit));
                if (CNT_W'(s) < ent_cnt[g]) begin
                    if (sc > gscore[g]) gscore[g] = sc;
                    ghits[g] = ghits[g] + CNT_W'(hit);
                end
            end
        end
    end

    always_comb begin
        logic [SCORE_W-1:0] best_s;
        logic [CNT_W-1:0]   best_h;
        pick_valid = 1'b0;
        pick_idx   = '0;
        best_s     = '0;
        best_h     = '0;
        for (int g = 0; g < NG; g++) begin
            if (ent_vld[g] && ent_closed[g]) begin
                if (!pick_valid || gscore[g] < best_s ||
                    (gscore[g] == best_s && ghits[g] > best_h)) begin
                    pick_valid = 1'b1;
                    pick_idx   = IDX_W'(g);
                    best_s     = gscore[g];
                    best_h     = ghits[g];
                end
            end
        end
    end

endmodule

// File: rtl/wgs_sched.sv
module wgs_sched
    import wgs_pkg::*;
#(
    parameter int NUM_GROUPS  = 8,
    parameter int GROUP_DEPTH = 8,
    parameter int NUM_BANKS   = 16,
    parameter int SM_W        = 4,
    parameter int WARP_W      = 6,
    parameter int ROW_W       = 12,
    localparam int BANK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int IDX_W   = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int CNT_W   = $clog2(GROUP_DEPTH + 1),
    localparam int SLOT_W  = (GROUP_DEPTH > 1) ? $clog2(GROUP_DEPTH) : 1,
    localparam int SCORE_W = $clog2(NUM_GROUPS * GROUP_DEPTH * 3 + 4) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SM_W-1:0]   in_sm,
    input  logic [WARP_W-1:0] in_warp,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [ROW_W-1:0]  in_row,
    input  logic              in_last,
    output logic              out_valid,
    output logic [SM_W-1:0]   out_sm,
    output logic [WARP_W-1:0] out_warp,
    output logic [BANK_W-1:0] out_bank,
    output logic [ROW_W-1:0]  out_row,
    output logic [1:0]        out_cost,
    output logic              out_last,
    input  logic              done_valid,
    input  logic [BANK_W-1:0] done_bank,
    input  logic [1:0]        done_cost
);

    logic               ent_vld    [NUM_GROUPS];
    logic               ent_closed [NUM_GROUPS];
    logic [CNT_W-1:0]   ent_cnt    [NUM_GROUPS];
    logic [SM_W-1:0]    ent_sm     [NUM_GROUPS];
    logic [WARP_W-1:0]  ent_warp   [NUM_GROUPS];
    logic [BANK_W-1:0]  ent_bank   [NUM_GROUPS][GROUP_DEPTH];
    logic [ROW_W-1:0]   ent_row    [NUM_GROUPS][GROUP_DEPTH];
    logic [ROW_W-1:0]   last_row   [NUM_BANKS];
    logic               row_seen   [NUM_BANKS];
    logic [SCORE_W-1:0] pend       [NUM_BANKS];

    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    disp_state_e      state;
    logic [IDX_W-1:0] cur;
    logic [SLOT_W-1:0] ptr;
    logic             send_hit;

    wgs_group_table #(
        .NG(NUM_GROUPS), .ND(GROUP_DEPTH), .SM_W(SM_W), .WARP_W(WARP_W),
        .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) grp_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_sm(in_sm), .in_warp(in_warp), .in_bank(in_bank), .in_row(in_row), .in_last(in_last),
        .free_valid(out_valid && out_last), .free_idx(cur),
        .ent_vld(ent_vld), .ent_closed(ent_closed), .ent_cnt(ent_cnt),
        .ent_sm(ent_sm), .ent_warp(ent_warp), .ent_bank(ent_bank), .ent_row(ent_row)
    );

    wgs_bank_table #(
        .NB(NUM_BANKS), .ROW_W(ROW_W), .SCORE_W(SCORE_W)
    ) bank_i (
        .clk(clk), .rst(rst),
        .upd_valid(out_valid), .upd_bank(out_bank), .upd_row(out_row), .upd_cost(out_cost),
        .done_valid(done_valid), .done_bank(done_bank), .done_cost(done_cost),
        .last_row(last_row), .row_seen(row_seen), .pend(pend)
    );

    wgs_picker #(
        .NG(NUM_GROUPS), .ND(GROUP_DEPTH), .NB(NUM_BANKS), .ROW_W(ROW_W), .SCORE_W(SCORE_W)
    ) pick_i (
        .ent_vld(ent_vld), .ent_closed(ent_closed), .ent_cnt(ent_cnt),
        .ent_bank(ent_bank), .ent_row(ent_row),
        .last_row(last_row), .row_seen(row_seen), .pend(pend),
        .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    always_comb begin
        out_valid = (state == ST_SEND);
        out_sm    = ent_sm[cur];
        out_warp  = ent_warp[cur];
        out_bank  = ent_bank[cur][ptr];
        out_row   = ent_row[cur][ptr];
        send_hit  = row_seen[out_bank] && (last_row[out_bank] == out_row);
        out_cost  = req_cost(send_hit);
        out_last  = (CNT_W'(ptr) + CNT_W'(1)) == ent_cnt[cur];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PICK;
            cur   <= '0;
            ptr   <= '0;
        end else begin
            case (state)
                ST_PICK: begin
                    if (pick_valid) begin
                        cur   <= pick_idx;
                        ptr   <= '0;
                        state <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (out_last) state <= ST_PICK;
                    else          ptr   <= ptr + SLOT_W'(1);
                end
                default: state <= ST_PICK;
            endcase
        end
    end

endmodule

// File: rtl/wgs_sched_chk.sv
module wgs_sched_chk #(
    parameter int SM_W   = 4,
    parameter int WARP_W = 6,
    parameter int BANK_W = 4,
    parameter int ROW_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic [SM_W-1:0]   out_sm,
    input logic [WARP_W-1:0] out_warp,
    input logic [BANK_W-1:0] out_bank,
    input logic [ROW_W-1:0]  out_row,
    input logic [1:0]        out_cost,
    input logic              out_last
);

    // R7: a group keeps the output busy until its final request
    a_r7_back_to_back: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_last |=> out_valid);

    // R7: one idle cycle separates groups
    a_r7_pick_gap: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |=> !out_valid);

    // R1: identity holds steady inside a group
    a_r1_same_group: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_last |=> out_sm == $past(out_sm) && out_warp == $past(out_warp));

    // R3: only the two cost codes ever leave the block
    a_r3_cost_legal: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_cost == 2'd1 || out_cost == 2'd3));

    // R3: a repeat of the previous bank and row is a hit
    a_r3_repeat_hit: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid) && out_bank == $past(out_bank) && out_row == $past(out_row)
        |-> out_cost == 2'd1);

    // R10: nothing is sent in the cycle after reset
    a_r10_quiet_reset: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind wgs_sched wgs_sched_chk #(
    .SM_W(SM_W), .WARP_W(WARP_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
) chk_i (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_sm(out_sm), .out_warp(out_warp),
    .out_bank(out_bank), .out_row(out_row), .out_cost(out_cost), .out_last(out_last)
);

// File: tb/wgs_sched_tb.sv
`timescale 1ns/1ps
module wgs_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_sm = '0;
    logic [5:0]  in_warp = '0;
    logic [3:0]  in_bank = '0;
    logic [11:0] in_row = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [3:0]  out_sm;
    logic [5:0]  out_warp;
    logic [3:0]  out_bank;
    logic [11:0] out_row;
    logic [1:0]  out_cost;
    logic        out_last;
    logic        done_valid = 1'b0;
    logic [3:0]  done_bank = '0;
    logic [1:0]  done_cost = '0;

    wgs_sched dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sm(in_sm), .in_warp(in_warp), .in_bank(in_bank), .in_row(in_row), .in_last(in_last),
        .out_valid(out_valid), .out_sm(out_sm), .out_warp(out_warp), .out_bank(out_bank),
        .out_row(out_row), .out_cost(out_cost), .out_last(out_last),
        .done_valid(done_valid), .done_bank(done_bank), .done_cost(done_cost)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int n = 0;
    int lg_bank [64];
    int lg_row  [64];
    int lg_sm   [64];
    int lg_warp [64];
    int lg_cost [64];
    int lg_last [64];
    int lg_cyc  [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid && n < 64) begin
            lg_bank[n] = out_bank; lg_row[n] = out_row; lg_sm[n] = out_sm;
            lg_warp[n] = out_warp; lg_cost[n] = out_cost; lg_last[n] = out_last;
            lg_cyc[n] = cyc;
            n = n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int sm, input int wp, input int bk, input int rw, input bit lst);
        @(negedge clk);
        in_sm = 4'(sm); in_warp = 6'(wp); in_bank = 4'(bk); in_row = 12'(rw); in_last = lst;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic done(input int bk, input int cs);
        @(negedge clk);
        done_valid = 1'b1; done_bank = 4'(bk); done_cost = 2'(cs);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (24) @(negedge clk);
    endtask

    task automatic expect_req(input int i, input string req, input int bk, input int rw, input int cs, input int lst);
        check(lg_bank[i] == bk, req, lg_bank[i], bk);
        check(lg_row[i] == rw, req, lg_row[i], rw);
        check(lg_cost[i] == cs, req, lg_cost[i], cs);
        check(lg_last[i] == lst, req, lg_last[i], lst);
    endtask

    // competition scenario stimulus: {sm, warp, bank, row, last}
    localparam logic [26:0] STIM_C [14] = '{
        {4'd2, 6'd0, 4'd5, 12'd0, 1'b0}, {4'd2, 6'd0, 4'd5, 12'd1, 1'b0},
        {4'd2, 6'd0, 4'd5, 12'd2, 1'b0}, {4'd2, 6'd0, 4'd5, 12'd3, 1'b0},
        {4'd2, 6'd0, 4'd5, 12'd4, 1'b0}, {4'd2, 6'd0, 4'd5, 12'd5, 1'b0},
        {4'd2, 6'd0, 4'd5, 12'd6, 1'b0}, {4'd2, 6'd0, 4'd5, 12'd7, 1'b1},
        {4'd3, 6'd0, 4'd0, 12'd9, 1'b1},
        {4'd3, 6'd1, 4'd2, 12'd5, 1'b1},
        {4'd3, 6'd2, 4'd0, 12'd5, 1'b0}, {4'd3, 6'd2, 4'd1, 12'd5, 1'b1},
        {4'd3, 6'd3, 4'd8, 12'd0, 1'b1},
        {4'd0, 6'd0, 4'd0, 12'd0, 1'b0}
    };
    // expected sends: {bank, row, cost, last}
    localparam logic [18:0] EXP_C [13] = '{
        {4'd5, 12'd0, 2'd3, 1'b0}, {4'd5, 12'd1, 2'd3, 1'b0}, {4'd5, 12'd2, 2'd3, 1'b0},
        {4'd5, 12'd3, 2'd3, 1'b0}, {4'd5, 12'd4, 2'd3, 1'b0}, {4'd5, 12'd5, 2'd3, 1'b0},
        {4'd5, 12'd6, 2'd3, 1'b0}, {4'd5, 12'd7, 2'd3, 1'b1},
        {4'd8, 12'd0, 2'd3, 1'b1},
        {4'd0, 12'd5, 2'd1, 1'b0}, {4'd1, 12'd5, 2'd1, 1'b1},
        {4'd2, 12'd5, 2'd1, 1'b1},
        {4'd0, 12'd9, 2'd3, 1'b1}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state at the ports
        check(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R10 idle after reset", out_valid, 0);

        // single group, fresh banks: misses, arrival order, identity
        send(1, 1, 0, 5, 0);
        send(1, 1, 1, 5, 0);
        send(1, 1, 2, 5, 1);
        drain();
        check(n == 3, "R1 group size", n, 3);
        for (int i = 0; i < 3; i++) begin
            expect_req(i, "R3 fresh bank miss", i, 5, 3, (i == 2) ? 1 : 0);
            check(lg_sm[i] == 1 && lg_warp[i] == 1, "R1 identity", lg_warp[i], 1);
        end

        // competing groups close while a long group is being sent
        for (int i = 0; i < 13; i++) begin
            logic [26:0] v;
            v = STIM_C[i];
            send(int'(v[26:23]), int'(v[22:17]), int'(v[16:13]), int'(v[12:1]), v[0]);
        end
        drain();
        check(n == 16, "R4 competition count", n, 16);
        for (int i = 0; i < 13; i++) begin
            logic [18:0] e;
            e = EXP_C[i];
            expect_req(3 + i, (i == 9 || i == 10) ? "R5 hit tie-break" : "R4 shortest first",
                       int'(e[18:15]), int'(e[14:3]), int'(e[2:1]), int'(e[0]));
        end
        for (int i = 1; i < 8; i++)
            check(lg_cyc[3 + i] == lg_cyc[3] + i, "R7 consecutive sends", lg_cyc[3 + i] - lg_cyc[3], i);
        check(lg_cyc[11] == lg_cyc[10] + 2, "R7 one idle cycle", lg_cyc[11] - lg_cyc[10], 2);

        // completion lowers a backlog so an older entry ties and wins on index
        for (int i = 0; i < 8; i++) send(2, 0, 5, 8 + i, i == 7);
        send(4, 1, 8, 2, 1);
        send(4, 0, 9, 0, 1);
        done(8, 3);
        drain();
        check(n == 26, "R8 count", n, 26);
        check(lg_bank[24] == 8 && lg_warp[24] == 1, "R8 R6 backlog relief and index tie", lg_bank[24], 8);
        check(lg_bank[25] == 9 && lg_warp[25] == 0, "R6 later entry second", lg_bank[25], 9);
        check(lg_cost[24] == 3, "R3 row change miss", lg_cost[24], 3);

        // depth closes a group without a last flag
        for (int i = 0; i < 8; i++) send(6, 0, 12, i, 0);
        drain();
        check(n == 34, "R2 depth close count", n, 34);
        check(lg_last[33] == 1 && lg_sm[33] == 6, "R2 final at depth", lg_last[33], 1);
        check(lg_last[32] == 0, "R2 not final before depth", lg_last[32], 0);

        // table full of open groups
        for (int i = 0; i < 8; i++) send(5, i, 10, i, 0);
        @(negedge clk);
        in_sm = 4'd5; in_warp = 6'd8;
        #1;
        check(in_ready == 1'b0, "R9 full table stalls new warp", in_ready, 0);
        in_warp = 6'd3;
        #1;
        check(in_ready == 1'b1, "R9 open warp still accepted", in_ready, 1);
        repeat (6) @(negedge clk);
        check(n == 34, "R2 open groups held", n, 34);
        for (int i = 0; i < 8; i++) send(5, i, 11, 0, 1);
        drain();
        check(n == 50, "R9 all drained", n, 50);
        @(negedge clk);
        in_warp = 6'd8;
        #1;
        check(in_ready == 1'b1, "R9 ready after drain", in_ready, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule